// File: doc/BRIEF.md
# Paging Frame Header Sequencer

This block follows a frame sync detector in a four-level FSK paging receiver. It takes an oversampled symbol stream, ten samples per bit at the base rate, along with a per-sample flag from the sync detector, the mode index of the matched sync word, and the bit-centre phase found by the detector. Once sync is seen and then lost, the block locks onto that centre phase. It reads a block of dotting bits plus a 32-bit frame header word from the centre samples and presents that word with a one-cycle valid pulse.

After the header word, the block switches to the bit rate and level count of the detected mode. At the doubled rate it halves the samples per bit and rescales its phase counter and centre so that later samples stay on bit centres. It then skips the second sync gap and opens a fixed-length payload window. During that window a downstream symbol decoder gets one strobe per bit centre. When the window closes, the block goes back to searching at the base rate.

Error correction of the header word is left to a later stage.

Top module: `frame_hdr_seq`

## Requirements
- R1: After reset, `state_o` is 0 (search), `baud` equals the base rate (1600), `levels` is 2, and `hdr_word_vld` and `data_stb` are low.
- R2: State codes are 0 search, 1 track, 2 header, 3 gap and 4 payload. A valid sample with `sync_hit` high moves search to track. The first valid sample in track with `sync_hit` low moves to header and latches `centre_in` and `mode_idx`. The sample counter clears to 0 on reset and on each return to search. It advances by one on every valid sample, wrapping at samples-per-bit, and a centre sample is one where the advanced count equals the latched centre.
- R3: In header state the block takes DOT_BITS+WORD_BITS (16+32) centre samples and shifts in `sym[1]`. After the last of them it shows the final WORD_BITS bits, earliest bit in the MSB, on `hdr_word` with `hdr_word_vld` high for exactly one cycle, and `state_o` becomes 3 in that same cycle.
- R4: The mode latched at the end of track sets the payload format: bit 1 selects double rate (3200, 5 samples per bit) and bit 0 selects 4 levels. `baud` and `levels` show this from entry to gap state until the return to search. Changes to `mode_idx` after the latch have no effect.
- R5: At the base rate, gap state lasts 40 centre samples. At double rate, entry to gap sets centre to centre/2 and phase to (phase/2 + 3) mod 5, and the gap lasts 81 centre samples: one alignment sample plus 80 bits.
- R6: Payload state lasts baud×PAYLOAD_MS/1000 centre samples. One cycle after each of them, `data_stb` pulses and `data_sym` holds that sample's symbol. No strobe appears outside payload.
- R7: After the last payload sample the block returns to search with 1600 baud and 2 levels, and the sample counter restarts from 0.
- R8: `sync_hit` is ignored in header, gap and payload states.
- R9: A cycle with `sym_valid` low changes no state, counter or output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | One oversampled symbol present this cycle |
| sym | input | 2 | Sliced four-level symbol, 0..3 |
| sync_hit | input | 1 | Sync detector matches on this sample |
| mode_idx | input | 2 | Mode of matched sync word: bit1 double rate, bit0 four levels |
| centre_in | input | 4 | Bit-centre phase at the base rate, 0..9 |
| state_o | output | 3 | Sequencer state code |
| hdr_word | output | 32 | Collected frame header word |
| hdr_word_vld | output | 1 | One-cycle pulse with a fresh header word |
| baud | output | 12 | Current bit rate in bit/s |
| levels | output | 3 | Current FSK level count, 2 or 4 |
| data_stb | output | 1 | Payload bit-centre strobe |
| data_sym | output | 2 | Symbol belonging to the strobe |

## Verification
The bench builds the block with its default rate, dotting, word and gap settings, but shortens the payload window to 20 ms: 32 strobes at 1600 and 64 at 3200. With this short window it can run every combination of the four modes and all ten centre phases, in frames both with and without idle cycles between samples. Each frame exercises the halving arithmetic at every centre value, the single extra alignment sample at double rate, the latching of the mode, and random sync flags in the states that ignore them. Expected state, word and strobe timing are derived by counting samples from the latch point.

// File: rtl/frame_hdr_pkg.sv
// Shared state encoding for the frame header sequencer.
package frame_hdr_pkg;

    typedef enum logic [2:0] {
        ST_SEARCH  = 3'd0,
        ST_TRACK   = 3'd1,
        ST_HDR     = 3'd2,
        ST_GAP     = 3'd3,
        ST_PAYLOAD = 3'd4
    } seq_state_e;

endpackage

// File: rtl/frame_hdr_phase.sv
// Sample phase tracker.
// Counts valid samples modulo samples-per-bit, holds the latched centre
// phase and flags centre samples. On a switch to the doubled rate it
// halves the centre and rescales the phase so the next centre falls on a
// bit middle. Assumes SPB_LO is even and SPB_HI == SPB_LO/2.
module frame_hdr_phase #(
    parameter int SPB_LO = 10,
    parameter int SPB_HI = 5,
    localparam int PW = $clog2(SPB_LO)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_valid,
    input  logic          rate_hi,
    input  logic          latch_c,
    input  logic          rescale,
    input  logic          clr,
    input  logic [PW-1:0] centre_in,
    output logic          centre_hit
);
    localparam logic [PW-1:0] LO_LAST = PW'(SPB_LO - 1);
    localparam logic [PW-1:0] HI_LAST = PW'(SPB_HI - 1);
    localparam logic [PW:0]   HI_N    = (PW+1)'(SPB_HI);
    localparam logic [PW:0]   HI_OFS  = (PW+1)'(SPB_HI - SPB_HI / 2);

    logic [PW-1:0] phase;
    logic [PW-1:0] centre_q;
    logic [PW-1:0] nxt;
    logic [PW:0]   fix_raw;
    logic [PW-1:0] fix;

    // next phase value after wrap at the current rate
    always_comb begin
        if (rate_hi)
            nxt = (phase == HI_LAST) ? '0 : phase + 1'b1;
        else
            nxt = (phase == LO_LAST) ? '0 : phase + 1'b1;
    end

    // rescaled phase for the rate switch: (nxt/2 - spb/2) mod spb
    always_comb begin
        fix_raw = {1'b0, nxt >> 1} + HI_OFS;
        fix     = (fix_raw >= HI_N) ? PW'(fix_raw - HI_N) : fix_raw[PW-1:0];
    end

    assign centre_hit = sym_valid && (nxt == centre_q);

    // phase and centre registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            centre_q <= '0;
        end else if (sym_valid) begin
            if (clr) begin
                phase    <= '0;
                centre_q <= '0;
            end else if (rescale) begin
                phase    <= fix;
                centre_q <= centre_q >> 1;
            end else begin
                phase <= nxt;
                if (latch_c)
                    centre_q <= centre_in;
            end
        end
    end

endmodule

// File: rtl/frame_hdr_word.sv
// Header word collector.
// Shifts in one bit per header centre sample and, on the final one,
// presents the last WORD_BITS bits (earliest in the MSB) with a one-cycle
// valid pulse. Assumes shift is high whenever done is high.
module frame_hdr_word #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic                 done,
    input  logic                 bit_in,
    output logic [WORD_BITS-1:0] word,
    output logic                 vld
);
    logic [WORD_BITS-1:0] sr;
    logic [WORD_BITS-1:0] sr_nxt;

    assign sr_nxt = {sr[WORD_BITS-2:0], bit_in};

    // shift register, captured word and valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            word <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= done;
            if (shift)
                sr <= sr_nxt;
            if (done)
                word <= sr_nxt;
        end
    end

endmodule

// File: rtl/frame_hdr_ctrl.sv
// Sequencer control.
// Walks search -> track -> header -> gap -> payload -> search, counting
// centre samples in each timed state and issuing the latch, shift,
// rescale and clear controls to the phase tracker and word collector.
// The gap count starts at all-ones at the doubled rate so one extra
// centre sample realigns the bit count after rescaling.
module frame_hdr_ctrl
    import frame_hdr_pkg::*;
#(
    parameter int BASE_BAUD  = 1600,
    parameter int DOT_BITS   = 16,
    parameter int WORD_BITS  = 32,
    parameter int GAP_MS     = 25,
    parameter int PAYLOAD_MS = 1760
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic       sync_hit,
    input  logic [1:0] mode_idx,
    input  logic       centre_hit,
    output seq_state_e state,
    output logic       rate_hi,
    output logic       four_lvl,
    output logic       latch_c,
    output logic       word_shift,
    output logic       word_done,
    output logic       rescale,
    output logic       go_idle
);
    localparam int HDR_N  = DOT_BITS + WORD_BITS;
    localparam int GAP_LO = BASE_BAUD * GAP_MS / 1000;
    localparam int GAP_HI = 2 * BASE_BAUD * GAP_MS / 1000;
    localparam int PAY_LO = BASE_BAUD * PAYLOAD_MS / 1000;
    localparam int PAY_HI = 2 * BASE_BAUD * PAYLOAD_MS / 1000;
    localparam int MAX_A  = (HDR_N > GAP_HI) ? HDR_N : GAP_HI;
    localparam int MAX_N  = (MAX_A > PAY_HI) ? MAX_A : PAY_HI;
    localparam int CW     = $clog2(MAX_N + 2);

    localparam logic [CW-1:0] HDR_C    = CW'(HDR_N);
    localparam logic [CW-1:0] GAP_LO_C = CW'(GAP_LO);
    localparam logic [CW-1:0] GAP_HI_C = CW'(GAP_HI);
    localparam logic [CW-1:0] PAY_LO_C = CW'(PAY_LO);
    localparam logic [CW-1:0] PAY_HI_C = CW'(PAY_HI);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] gap_tgt;
    logic [CW-1:0] pay_tgt;
    logic [1:0]    mode_q;
    logic          gap_done;

    // counter terminal values for the current rate
    always_comb begin
        cnt_inc = cnt + 1'b1;
        gap_tgt = rate_hi ? GAP_HI_C : GAP_LO_C;
        pay_tgt = rate_hi ? PAY_HI_C : PAY_LO_C;
    end

    // control strobes to the phase tracker and word collector
    always_comb begin
        latch_c    = (state == ST_TRACK) && sym_valid && !sync_hit;
        word_shift = (state == ST_HDR) && centre_hit;
        word_done  = word_shift && (cnt_inc == HDR_C);
        rescale    = word_done && mode_q[1];
        gap_done   = (state == ST_GAP) && centre_hit && (cnt_inc == gap_tgt);
        go_idle    = (state == ST_PAYLOAD) && centre_hit && (cnt_inc == pay_tgt);
    end

    // state, counter and rate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SEARCH;
            cnt      <= '0;
            rate_hi  <= 1'b0;
            four_lvl <= 1'b0;
            mode_q   <= 2'b00;
        end else begin
            case (state)
                ST_SEARCH: begin
                    if (sym_valid && sync_hit)
                        state <= ST_TRACK;
                end
                ST_TRACK: begin
                    if (latch_c) begin
                        state  <= ST_HDR;
                        cnt    <= '0;
                        mode_q <= mode_idx;
                    end
                end
                ST_HDR: begin
                    if (word_done) begin
                        state    <= ST_GAP;
                        rate_hi  <= mode_q[1];
                        four_lvl <= mode_q[0];
                        cnt      <= mode_q[1] ? '1 : '0;
                    end else if (word_shift) begin
                        cnt <= cnt_inc;
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        state <= ST_PAYLOAD;
                        cnt   <= '0;
                    end else if (centre_hit) begin
                        cnt <= cnt_inc;
                    end
                end
                ST_PAYLOAD: begin
                    if (go_idle) begin
                        state    <= ST_SEARCH;
                        cnt      <= '0;
                        rate_hi  <= 1'b0;
                        four_lvl <= 1'b0;
                        mode_q   <= 2'b00;
                    end else if (centre_hit) begin
                        cnt <= cnt_inc;
                    end
                end
                default: state <= ST_SEARCH;
            endcase
        end
    end

endmodule

// File: rtl/frame_hdr_seq.sv
// Frame header sequencer top.
// Ties the control FSM, phase tracker and header word collector together
// and registers the payload strobe and symbol. Assumes centre_in is below
// the base samples-per-bit whenever the track state ends.
module frame_hdr_seq
    import frame_hdr_pkg::*;
#(
    parameter int SAMPLE_HZ  = 16000,
    parameter int BASE_BAUD  = 1600,
    parameter int DOT_BITS   = 16,
    parameter int WORD_BITS  = 32,
    parameter int GAP_MS     = 25,
    parameter int PAYLOAD_MS = 1760,
    localparam int SPB_LO = SAMPLE_HZ / BASE_BAUD,
    localparam int SPB_HI = SAMPLE_HZ / (2 * BASE_BAUD),
    localparam int PW     = $clog2(SPB_LO),
    localparam int BW     = $clog2(2 * BASE_BAUD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sym_valid,
    input  logic [1:0]           sym,
    input  logic                 sync_hit,
    input  logic [1:0]           mode_idx,
    input  logic [PW-1:0]        centre_in,
    output logic [2:0]           state_o,
    output logic [WORD_BITS-1:0] hdr_word,
    output logic                 hdr_word_vld,
    output logic [BW-1:0]        baud,
    output logic [2:0]           levels,
    output logic                 data_stb,
    output logic [1:0]           data_sym
);
    seq_state_e state;
    logic rate_hi, four_lvl, latch_c, word_shift, word_done;
    logic rescale, go_idle, centre_hit;

    frame_hdr_ctrl #(
        .BASE_BAUD (BASE_BAUD),
        .DOT_BITS  (DOT_BITS),
        .WORD_BITS (WORD_BITS),
        .GAP_MS    (GAP_MS),
        .PAYLOAD_MS(PAYLOAD_MS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sync_hit  (sync_hit),
        .mode_idx  (mode_idx),
        .centre_hit(centre_hit),
        .state     (state),
        .rate_hi   (rate_hi),
        .four_lvl  (four_lvl),
        .latch_c   (latch_c),
        .word_shift(word_shift),
        .word_done (word_done),
        .rescale   (rescale),
        .go_idle   (go_idle)
    );

    frame_hdr_phase #(
        .SPB_LO(SPB_LO),
        .SPB_HI(SPB_HI)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .rate_hi   (rate_hi),
        .latch_c   (latch_c),
        .rescale   (rescale),
        .clr       (go_idle),
        .centre_in (centre_in),
        .centre_hit(centre_hit)
    );

    frame_hdr_word #(
        .WORD_BITS(WORD_BITS)
    ) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (word_shift),
        .done  (word_done),
        .bit_in(sym[1]),
        .word  (hdr_word),
        .vld   (hdr_word_vld)
    );

    assign state_o = state;
    assign baud    = rate_hi ? BW'(2 * BASE_BAUD) : BW'(BASE_BAUD);
    assign levels  = four_lvl ? 3'd4 : 3'd2;

    // payload strobe and symbol, one cycle after each payload centre sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_stb <= 1'b0;
            data_sym <= 2'b00;
        end else begin
            data_stb <= (state == ST_PAYLOAD) && centre_hit;
            if ((state == ST_PAYLOAD) && centre_hit)
                data_sym <= sym;
        end
    end

endmodule

// File: rtl/frame_hdr_seq_chk.sv
// Property checker for the frame header sequencer, bound to the top.
module frame_hdr_seq_chk #(
    parameter int BASE_BAUD = 1600,
    localparam int BW = $clog2(2 * BASE_BAUD + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sym_valid,
    input logic [2:0]    state_o,
    input logic          hdr_word_vld,
    input logic [BW-1:0] baud,
    input logic [2:0]    levels,
    input logic          data_stb
);
    // R3
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_word_vld |=> !hdr_word_vld);

    // R3
    word_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_word_vld |-> (state_o == 3'd3) && ($past(state_o) == 3'd2));

    // R2
    legal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |->
            ((state_o == $past(state_o) + 3'd1) ||
             ((state_o == 3'd0) && ($past(state_o) == 3'd4))));

    // R6
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> ($past(state_o) == 3'd4));

    // R7
    base_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> ((baud == BW'(BASE_BAUD)) && (levels == 3'd2)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sym_valid)) |-> ($stable(state_o) && !data_stb && !hdr_word_vld));

endmodule

bind frame_hdr_seq frame_hdr_seq_chk #(.BASE_BAUD(BASE_BAUD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid   (sym_valid),
    .state_o     (state_o),
    .hdr_word_vld(hdr_word_vld),
    .baud        (baud),
    .levels      (levels),
    .data_stb    (data_stb)
);

// File: tb/frame_hdr_seq_bench.sv
module frame_hdr_seq_bench;
    localparam int PAY_MS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym = 2'd0;
    logic        sync_hit = 1'b0;
    logic [1:0]  mode_idx = 2'd0;
    logic [3:0]  centre_in = 4'd0;
    logic [2:0]  state_o;
    logic [31:0] hdr_word;
    logic        hdr_word_vld;
    logic [11:0] baud;
    logic [2:0]  levels;
    logic        data_stb;
    logic [1:0]  data_sym;

    int n_chk = 0;
    int n_fail = 0;
    int n = 0;

    always #4 clk = ~clk;

    frame_hdr_seq #(.PAYLOAD_MS(PAY_MS)) u_frame_hdr_seq (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .sync_hit(sync_hit), .mode_idx(mode_idx), .centre_in(centre_in),
        .state_o(state_o), .hdr_word(hdr_word), .hdr_word_vld(hdr_word_vld),
        .baud(baud), .levels(levels), .data_stb(data_stb), .data_sym(data_sym)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (sample %0d)", req, act, exp, n);
        end
    endtask

    // one valid sample, optionally preceded by an idle cycle (R9)
    task automatic push(input logic [1:0] s, input logic h, input bit gap);
        logic [2:0] prev;
        if (gap) begin
            prev = state_o;
            sym_valid = 1'b0; sym = 2'($urandom); sync_hit = 1'b1;
            @(posedge clk); @(negedge clk);
            check("R9 state", 64'(state_o), 64'(prev));
            check("R9 strobe", 64'(data_stb), 64'd0);
            check("R9 word valid", 64'(hdr_word_vld), 64'd0);
        end
        sym_valid = 1'b1; sym = s; sync_hit = h;
        @(posedge clk); @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic run_frame(input int mode, input int c, input bit gaps);
        int spb, bd, dlen, n_e, first, n_f, s2_end, d_end, exp_st;
        logic [31:0] w;
        logic [1:0] s;
        bit hi;
        hi   = mode[1];
        spb  = hi ? 5 : 10;
        bd   = hi ? 3200 : 1600;
        dlen = bd * PAY_MS / 1000;
        w    = $urandom;
        centre_in = 4'(c);
        mode_idx  = 2'(mode);
        for (int k = 0; k < 2; k++) begin
            n++; push(2'($urandom), 1'b0, 1'b0);
            check("R2 search holds", 64'(state_o), 64'd0);
        end
        for (int k = 0; k < 3; k++) begin
            n++; push(2'($urandom), 1'b1, 1'b0);
            check("R2 track", 64'(state_o), 64'd1);
        end
        n++; push(2'($urandom), 1'b0, 1'b0);
        n_e = n;
        check("R2 header entry", 64'(state_o), 64'd2);
        mode_idx = ~2'(mode);   // R4: later mode changes ignored
        first = n_e + 1;
        while (first % 10 != c) first++;
        n_f    = first + 470;
        s2_end = hi ? n_f + 2 + 400 : n_f + 400;
        d_end  = s2_end + spb * dlen;
        for (int m = n_e + 1; m <= d_end; m++) begin
            n = m;
            if (m >= first && m <= n_f && (m - first) % 10 == 0) begin
                int idx;
                bit b;
                idx = (m - first) / 10 + 1;
                b = (idx <= 16) ? idx[0] : w[48 - idx];
                s = {b, 1'($urandom)};
            end else begin
                s = 2'($urandom);
            end
            push(s, 1'($urandom), gaps && (m % 7 == 0));  // R8 random hits
            if (m < n_f) exp_st = 2;
            else if (m < s2_end) exp_st = 3;
            else if (m < d_end) exp_st = 4;
            else exp_st = 0;
            check("R5/R8 state", 64'(state_o), 64'(exp_st));
            check("R3 word valid", 64'(hdr_word_vld), 64'(m == n_f));
            if (m == n_f) check("R3 word", 64'(hdr_word), 64'(w));
            if (m >= n_f && m < d_end) begin
                check("R4 baud", 64'(baud), 64'(bd));
                check("R4 levels", 64'(levels), mode[0] ? 64'd4 : 64'd2);
            end else begin
                check("R7 baud", 64'(baud), 64'd1600);
                check("R7 levels", 64'(levels), 64'd2);
            end
            if (m > s2_end && (m - s2_end) % spb == 0) begin
                check("R6 strobe", 64'(data_stb), 64'd1);
                check("R6 symbol", 64'(data_sym), 64'(s));
            end else begin
                check("R6 no strobe", 64'(data_stb), 64'd0);
            end
        end
        n = 0;   // R7: phase restarts
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 state", 64'(state_o), 64'd0);
        check("R1 baud", 64'(baud), 64'd1600);
        check("R1 levels", 64'(levels), 64'd2);
        check("R1 strobe", 64'(data_stb), 64'd0);
        check("R1 word valid", 64'(hdr_word_vld), 64'd0);
        rst_n = 1'b1;
        for (int md = 0; md < 4; md++)
            for (int c = 0; c < 10; c++)
                run_frame(md, c, (c % 2) == 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule